// File: doc/BRIEF.md
# Power-On Fail-Safe Fan Sequencer

This block decides what the fans do after power-up, before host software has set up the device. A fail-safe window starts when reset is released. The window is counted in timer ticks. If the host makes a valid bus access inside that window, the block goes to normal operation and the default register set takes effect.

If the window runs out with no bus access, the block looks at a core-voltage-good flag. The flag comes from an external comparator with a fixed threshold and is high when the processor rail is above that threshold. With the rail powered, the fans are forced to full speed. With the rail unpowered, the fans are switched off.

After the timeout, the block keeps following the voltage flag, moving between full speed and off. A valid bus access at any point moves it to normal operation, and it stays there until reset.

Top module: `pfs_top`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `fan_mode` reads 2'b11 (waiting) and `regs_ready` is 0.
- R2: A `bus_hit` high at a clock edge while waiting gives `fan_mode` 2'b00 (normal) after that edge. This also holds when the final timeout tick arrives at the same edge.
- R3: While waiting, only clock edges with `tick` high advance the window. The block leaves the waiting state at the edge that carries the `TIMEOUT_TICKS`-th tick, and not at any earlier edge.
- R4: If `vcore_ok` is high at the timeout edge, `fan_mode` becomes 2'b01 (full speed).
- R5: If `vcore_ok` is low at the timeout edge, `fan_mode` becomes 2'b10 (off).
- R6: From full speed or off, a `bus_hit` at an edge gives normal (2'b00) after that edge.
- R7: In full speed with no `bus_hit`, `vcore_ok` low at an edge gives off after it. In off with no `bus_hit`, `vcore_ok` high at an edge gives full speed after it.
- R8: Once normal, `fan_mode` stays 2'b00 whatever `bus_hit`, `tick` and `vcore_ok` do, until reset.
- R9: `regs_ready` is 1 exactly when `fan_mode` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, power-up point |
| vcore_ok | input | 1 | Core rail above threshold (comparator output) |
| bus_hit | input | 1 | One-cycle pulse per valid host bus transaction |
| tick | input | 1 | Fail-safe timer tick enable |
| fan_mode | output | 2 | 00 normal, 01 full speed, 10 off, 11 waiting |
| regs_ready | output | 1 | Default register set in effect |

## Verification
The bench sets `TIMEOUT_TICKS` to 16. This brings the timeout edge, and the edge one tick before it, within a few dozen cycles, while the ticks still arrive with irregular gaps so that idle cycles are seen not to advance the window. At that size the bench can run several power-up sequences: early bus access, a timeout with the rail powered, a timeout with the rail unpowered, and a bus access that lands on the same edge as the final tick. Each sequence is followed by voltage toggling and late bus accesses.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_FULL   = 2'b01,
    MODE_OFF    = 2'b10,
    MODE_WAIT   = 2'b11
  } fan_mode_e;

  // Next-mode rule: a bus access always wins, then the timeout, then the rail.
  function automatic fan_mode_e next_mode(input fan_mode_e cur,
                                          input logic      bus,
                                          input logic      expire,
                                          input logic      vok);
    fan_mode_e nxt;
    nxt = cur;
    case (cur)
      MODE_WAIT: begin
        if (bus)         nxt = MODE_NORMAL;
        else if (expire) nxt = vok ? MODE_FULL : MODE_OFF;
      end
      MODE_FULL: begin
        if (bus)         nxt = MODE_NORMAL;
        else if (!vok)   nxt = MODE_OFF;
      end
      MODE_OFF: begin
        if (bus)         nxt = MODE_NORMAL;
        else if (vok)    nxt = MODE_FULL;
      end
      default:           nxt = MODE_NORMAL;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pfs_timer.sv
module pfs_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step   = run & tick;
  assign expire = step & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (step && cnt_q != LAST)
      cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("window counter past limit"); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q)) else $error("window moved without tick"); // R3

endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_hit,
  input  logic      expire,
  input  logic      vcore_ok,
  output fan_mode_e mode_q,
  output logic      waiting
);
  fan_mode_e mode_d;

  assign mode_d  = next_mode(mode_q, bus_hit, expire, vcore_ok);
  assign waiting = (mode_q == MODE_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_WAIT;
    else        mode_q <= mode_d;
  end

  AST_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |=> mode_q == MODE_NORMAL) else $error("bus access ignored"); // R2

  AST_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_WAIT && !bus_hit && !expire) |=> mode_q == MODE_WAIT)
    else $error("left window early"); // R3

  AST_TIMEOUT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_WAIT && expire && !bus_hit) |=>
      mode_q == ($past(vcore_ok) ? MODE_FULL : MODE_OFF))
    else $error("wrong timeout outcome"); // R4

  AST_FULL_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FULL && !bus_hit && !vcore_ok) |=> mode_q == MODE_OFF)
    else $error("full did not drop to off"); // R7

  AST_OFF_TO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF && !bus_hit && vcore_ok) |=> mode_q == MODE_FULL)
    else $error("off did not return to full"); // R7

  AST_NORMAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MODE_NORMAL |=> mode_q == MODE_NORMAL)
    else $error("left normal"); // R8

endmodule

// File: rtl/pfs_top.sv
module pfs_top #(
  parameter int TIMEOUT_TICKS = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcore_ok,
  input  logic       bus_hit,
  input  logic       tick,
  output logic [1:0] fan_mode,
  output logic       regs_ready
);
  import pfs_pkg::*;

  fan_mode_e mode_q;
  logic      waiting;
  logic      expire;

  pfs_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (waiting),
    .tick   (tick),
    .expire (expire)
  );

  pfs_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_hit  (bus_hit),
    .expire   (expire),
    .vcore_ok (vcore_ok),
    .mode_q   (mode_q),
    .waiting  (waiting)
  );

  assign fan_mode   = mode_q;
  assign regs_ready = (mode_q == MODE_NORMAL);

  AST_RESET_WAIT: assert property (@(posedge clk)
    !rst_n |=> fan_mode == 2'b11) else $error("reset not waiting"); // R1

  AST_READY_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(regs_ready) |-> $past(bus_hit)) else $error("ready without bus"); // R9

endmodule

// File: tb/tb_pfs_top.sv
module tb_pfs_top;
  localparam int T = 16;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       vcore_ok = 0;
  logic       bus_hit = 0;
  logic       tick = 0;
  logic [1:0] fan_mode;
  logic       regs_ready;

  int checks = 0;
  int errors = 0;
  int m_mode = 3;
  int m_cnt  = 0;

  always #4 clk = ~clk;

  pfs_top #(.TIMEOUT_TICKS(T)) dut (
    .clk(clk), .rst_n(rst_n), .vcore_ok(vcore_ok), .bus_hit(bus_hit),
    .tick(tick), .fan_mode(fan_mode), .regs_ready(regs_ready)
  );

  task automatic compare(input string req);
    checks++;
    if (int'(fan_mode) != m_mode) begin
      errors++;
      $display("FAIL %s: fan_mode=%0d expected %0d", req, fan_mode, m_mode);
    end
    checks++;
    if (regs_ready != (m_mode == 0)) begin
      errors++;
      $display("FAIL R9: regs_ready=%0d expected %0d", regs_ready, m_mode == 0);
    end
  endtask

  task automatic model(input logic b, input logic t, input logic v);
    case (m_mode)
      3: if (b) m_mode = 0;
         else if (t) begin
           m_cnt++;
           if (m_cnt == T) m_mode = v ? 1 : 2;
         end
      1: if (b) m_mode = 0; else if (!v) m_mode = 2;
      2: if (b) m_mode = 0; else if (v) m_mode = 1;
      default: m_mode = 0;
    endcase
  endtask

  task automatic step(input logic b, input logic t, input logic v, input string req);
    @(negedge clk);
    bus_hit = b; tick = t; vcore_ok = v;
    @(posedge clk);
    model(b, t, v);
    #2;
    compare(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_hit = 0; tick = 0; vcore_ok = 0;
    repeat (3) @(posedge clk);
    m_mode = 3; m_cnt = 0;
    #2; compare("R1");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2; compare("R1");
  endtask

  // ticks with gaps; 'n' ticks delivered, idle cycles between
  task automatic run_ticks(input int n, input logic v, input string req);
    for (int i = 0; i < n; i++) begin
      step(0, 1, v, req);
      if (i % 3 == 1) step(0, 0, v, "R3");
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // early bus access, then normal must stick
    do_reset();
    run_ticks(5, 1, "R3");
    step(1, 0, 1, "R2");
    for (int i = 0; i < 2 * T; i++) step(i % 2, 1, i % 3 == 0, "R8");

    // timeout with rail up, then rail toggling, then bus
    do_reset();
    run_ticks(T - 1, 1, "R3");
    step(0, 0, 1, "R3");
    step(0, 1, 1, "R4");
    step(0, 1, 1, "R4");
    step(0, 0, 0, "R7");
    step(0, 0, 0, "R7");
    step(0, 1, 1, "R7");
    step(1, 0, 1, "R6");
    step(0, 0, 0, "R8");

    // timeout with rail down, then bus from off
    do_reset();
    run_ticks(T - 1, 0, "R3");
    step(0, 1, 0, "R5");
    step(0, 1, 0, "R5");
    step(1, 0, 0, "R6");
    step(0, 0, 1, "R8");

    // bus on the same edge as the final tick
    do_reset();
    run_ticks(T - 1, 1, "R3");
    step(1, 1, 1, "R2");
    step(0, 1, 0, "R8");

    // rail flip between last-but-one tick and the timeout edge
    do_reset();
    run_ticks(T - 1, 1, "R3");
    step(0, 1, 0, "R5");
    step(0, 0, 1, "R7");
    step(0, 0, 1, "R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule